// File: doc/BRIEF.md
# Multi-Line Program Pulse Scheduler

This block plans how a write-verify driver fires program pulses into one square block of a resistive crossbar. Two count maps are held per cell: one with the number of set pulses each cell still needs and one with the number of reset pulses. A start request runs the set map down to zero first, then the reset map. Each iteration pulses a group of rows and columns together. On each iteration the block publishes a row-enable mask and a column-enable mask with a valid/ready handshake. When the driver accepts the pulse, every cell where an enabled row meets an enabled column loses one count.

The grouping rule works in three steps. The pivot is the column whose remaining counts add up to the most, and the leftmost column wins a tie. The enabled rows are the rows where the pivot column still has a nonzero count. Every column that has a nonzero count on all of those rows joins the group. A run is either coarse or fine. The two differ only in the step size reported beside each pulse, so a coarse sweep and a later fine-tuning sweep reuse the same rule. The number of accepted pulses in the current run is always visible. A done flag rises when both maps are empty.

Top module: `pulse_sched`

## Requirements
- R1: After reset, `done` is 0, `pulseValid` is 0, `iterCount` is 0, and both maps hold only zeros.
- R2: For each offered pulse, the pivot column is the one with the largest sum of remaining counts in the active map, and the leftmost column (lowest index, column c at bit c of `colEn`) wins a tie. `rowEn` bit r is 1 exactly when row r of the pivot column holds a nonzero count, and `rowEn` is never zero while `pulseValid` is high.
- R3: `colEn` bit c is 1 exactly when column c holds a nonzero count on every row enabled in `rowEn`. The pivot column is therefore always included.
- R4: While `pulseValid` is high and `pulseReady` is low, `rowEn`, `colEn`, `pulseReset` and `stepSize` hold their values. On acceptance (`pulseValid` and `pulseReady` high at a clock edge), each cell of the active map at an enabled row and an enabled column is decremented by one.
- R5: A run offers pulses from the set map (`pulseReset`=0) until that map is all zero, and only then offers pulses from the reset map (`pulseReset`=1).
- R6: When both maps are all zero, `done` rises and stays high with `pulseValid` low until the next accepted start. A start on empty maps completes with zero pulses.
- R7: `stepSize` equals COARSE_STEP for a run started with `fineMode`=0 and FINE_STEP for a run started with `fineMode`=1. The value is captured at start and kept for the whole run.
- R8: `iterCount` is cleared by an accepted start and increases by one on each accepted pulse.
- R9: `loadEn` writes `loadVal` into cell (`loadRow`, `loadCol`) of the set map (`loadMap`=0) or the reset map (`loadMap`=1) only while the block is idle. While a run is in progress, `loadEn` and `start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write one map cell (idle only) |
| loadMap | input | 1 | 0 selects the set map, 1 the reset map |
| loadRow | input | RIDX_W | Row index of the written cell |
| loadCol | input | CIDX_W | Column index of the written cell |
| loadVal | input | CNT_W | Pulse count written |
| start | input | 1 | Begin a run (idle only) |
| fineMode | input | 1 | Run type captured at start: 0 coarse, 1 fine |
| pulseValid | output | 1 | A pulse group is offered |
| pulseReady | input | 1 | Driver accepts the offered group |
| rowEn | output | ROWS | Row-enable mask, bit r is row r |
| colEn | output | COLS | Column-enable mask, bit c is column c |
| pulseReset | output | 1 | 1 when the group comes from the reset map |
| stepSize | output | STEP_W | Step size for this run |
| iterCount | output | ITER_W | Accepted pulses since the last start |
| done | output | 1 | Both maps are empty and the run has finished |

## Verification
The assertions take it that `pulseReady` may take any value in any cycle, and that `start` and `loadEn` may arrive during a run and must then be dropped. They also take it that `iterCount` never reaches its saturation limit within one run. The stimulus keeps map values inside the counter width and holds runs far below the counter limit. It stalls the handshake with a pseudo-random ready pattern, and it injects stray loads and a stray start with the opposite run type while busy. A fresh run started on the expected empty maps then shows that none of the stray writes took effect.

// File: rtl/pulse_sched_pkg.sv
package pulse_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLAN  = 2'd1,
    ST_ISSUE = 2'd2
  } schedState_t;

  typedef struct packed {
    logic loadWr;
    logic latchPlan;
    logic applyPulse;
    logic useReset;
  } schedStrobe_t;

endpackage

// File: rtl/pulse_sched_dp.sv
module pulse_sched_dp
  import pulse_sched_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int CNT_W  = 4,
  parameter int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int CIDX_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  schedStrobe_t      strb,
  input  logic              loadMap,
  input  logic [RIDX_W-1:0] loadRow,
  input  logic [CIDX_W-1:0] loadCol,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [ROWS-1:0]   rowEn,
  output logic [COLS-1:0]   colEn,
  output logic              mapEmpty
);

  localparam int SUM_W = CNT_W + $clog2(ROWS) + 1;

  logic [ROWS*COLS-1:0][CNT_W-1:0] actMap;
  logic [SUM_W-1:0]  colSum [COLS];
  logic [ROWS-1:0]   nzCol  [COLS];
  logic [SUM_W-1:0]  bestSum;
  logic [CIDX_W-1:0] pivotIdx;
  logic [ROWS-1:0]   rowSel;
  logic [COLS-1:0]   colSel;

  // One storage cell per crossbar position, holding both counts
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      logic [CNT_W-1:0] setQ;
      logic [CNT_W-1:0] rstQ;
      logic             hitLoad;
      logic             hitPulse;

      assign hitLoad  = strb.loadWr && (loadRow == RIDX_W'(r)) && (loadCol == CIDX_W'(c));
      assign hitPulse = strb.applyPulse && rowEn[r] && colEn[c];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          setQ <= '0;
          rstQ <= '0;
        end else if (hitLoad) begin
          if (loadMap) rstQ <= loadVal;
          else         setQ <= loadVal;
        end else if (hitPulse) begin
          if (strb.useReset) begin
            if (rstQ != '0) rstQ <= rstQ - 1'b1;
          end else begin
            if (setQ != '0) setQ <= setQ - 1'b1;
          end
        end
      end

      assign actMap[r*COLS + c] = strb.useReset ? rstQ : setQ;
    end
  end

  // Column totals and nonzero patterns of the active map
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      colSum[c] = '0;
      nzCol[c]  = '0;
      for (int r = 0; r < ROWS; r++) begin
        colSum[c]   = colSum[c] + SUM_W'(actMap[r*COLS + c]);
        nzCol[c][r] = (actMap[r*COLS + c] != '0);
      end
    end
  end

  // Pivot search: strict compare keeps the leftmost column on a tie
  always_comb begin
    bestSum  = '0;
    pivotIdx = '0;
    for (int c = 0; c < COLS; c++) begin
      if (colSum[c] > bestSum) begin
        bestSum  = colSum[c];
        pivotIdx = CIDX_W'(c);
      end
    end
    rowSel = nzCol[pivotIdx];
    for (int c = 0; c < COLS; c++) begin
      colSel[c] = (rowSel != '0) && ((rowSel & ~nzCol[c]) == '0);
    end
  end

  assign mapEmpty = (bestSum == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowEn <= '0;
      colEn <= '0;
    end else if (strb.latchPlan) begin
      rowEn <= rowSel;
      colEn <= colSel;
    end
  end

endmodule

// File: rtl/pulse_sched_ctrl.sv
module pulse_sched_ctrl
  import pulse_sched_pkg::*;
#(
  parameter int ITER_W      = 16,
  parameter int STEP_W      = 4,
  parameter int COARSE_STEP = 4,
  parameter int FINE_STEP   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              start,
  input  logic              fineMode,
  input  logic              mapEmpty,
  input  logic              pulseReady,
  output schedStrobe_t      strb,
  output logic              pulseValid,
  output logic              pulseReset,
  output logic [STEP_W-1:0] stepSize,
  output logic [ITER_W-1:0] iterCount,
  output logic              done
);

  schedState_t state;
  logic        useResetQ;
  logic        fineQ;

  assign pulseValid = (state == ST_ISSUE);
  assign pulseReset = useResetQ;
  assign stepSize   = fineQ ? STEP_W'(FINE_STEP) : STEP_W'(COARSE_STEP);

  always_comb begin
    strb            = '0;
    strb.loadWr     = loadEn && (state == ST_IDLE);
    strb.latchPlan  = (state == ST_PLAN) && !mapEmpty;
    strb.applyPulse = (state == ST_ISSUE) && pulseReady;
    strb.useReset   = useResetQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      useResetQ <= 1'b0;
      fineQ     <= 1'b0;
      iterCount <= '0;
      done      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_PLAN;
            useResetQ <= 1'b0;
            fineQ     <= fineMode;
            iterCount <= '0;
            done      <= 1'b0;
          end
        end
        ST_PLAN: begin
          if (mapEmpty) begin
            if (!useResetQ) begin
              useResetQ <= 1'b1;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (pulseReady) begin
            state <= ST_PLAN;
            if (iterCount != '1) iterCount <= iterCount + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pulse_sched.sv
module pulse_sched
  import pulse_sched_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int COLS        = 8,
  parameter int CNT_W       = 4,
  parameter int ITER_W      = 16,
  parameter int STEP_W      = 4,
  parameter int COARSE_STEP = 4,
  parameter int FINE_STEP   = 1,
  parameter int RIDX_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int CIDX_W      = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              loadMap,
  input  logic [RIDX_W-1:0] loadRow,
  input  logic [CIDX_W-1:0] loadCol,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic              start,
  input  logic              fineMode,
  output logic              pulseValid,
  input  logic              pulseReady,
  output logic [ROWS-1:0]   rowEn,
  output logic [COLS-1:0]   colEn,
  output logic              pulseReset,
  output logic [STEP_W-1:0] stepSize,
  output logic [ITER_W-1:0] iterCount,
  output logic              done
);

  schedStrobe_t strb;
  logic         mapEmpty;

  pulse_sched_ctrl #(
    .ITER_W(ITER_W), .STEP_W(STEP_W),
    .COARSE_STEP(COARSE_STEP), .FINE_STEP(FINE_STEP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .start(start),
    .fineMode(fineMode), .mapEmpty(mapEmpty), .pulseReady(pulseReady),
    .strb(strb), .pulseValid(pulseValid), .pulseReset(pulseReset),
    .stepSize(stepSize), .iterCount(iterCount), .done(done)
  );

  pulse_sched_dp #(
    .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W),
    .RIDX_W(RIDX_W), .CIDX_W(CIDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadMap(loadMap),
    .loadRow(loadRow), .loadCol(loadCol), .loadVal(loadVal),
    .rowEn(rowEn), .colEn(colEn), .mapEmpty(mapEmpty)
  );

endmodule

// File: rtl/pulse_sched_chk.sv
module pulse_sched_chk #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int ITER_W = 16,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              pulseValid,
  input logic              pulseReady,
  input logic [ROWS-1:0]   rowEn,
  input logic [COLS-1:0]   colEn,
  input logic              pulseReset,
  input logic [STEP_W-1:0] stepSize,
  input logic [ITER_W-1:0] iterCount,
  input logic              done
);

  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pulseValid && !pulseReady) |=> (pulseValid && $stable(rowEn) && $stable(colEn) && $stable(pulseReset))); // R4

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    pulseValid |-> ((rowEn != '0) && (colEn != '0))); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pulseValid); // R6

  AST_ITER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pulseValid && pulseReady && (iterCount != '1)) |=> (iterCount == $past(iterCount) + 1'b1)); // R8

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (pulseReset && !start) |=> pulseReset); // R5

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(stepSize)); // R7

endmodule

bind pulse_sched pulse_sched_chk #(
  .ROWS(ROWS), .COLS(COLS), .ITER_W(ITER_W), .STEP_W(STEP_W)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .pulseValid(pulseValid),
  .pulseReady(pulseReady), .rowEn(rowEn), .colEn(colEn),
  .pulseReset(pulseReset), .stepSize(stepSize), .iterCount(iterCount),
  .done(done)
);

// File: tb/pulse_sched_tb_top.sv
module pulse_sched_tb_top;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int CNT_W = 4;
  localparam int ITER_W = 16;
  localparam int STEP_W = 4;
  localparam int COARSE = 4;
  localparam int FINE = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0, loadMap = 1'b0;
  logic [2:0] loadRow = '0, loadCol = '0;
  logic [CNT_W-1:0] loadVal = '0;
  logic start = 1'b0, fineMode = 1'b0, pulseReady = 1'b0;
  logic pulseValid, pulseReset, done;
  logic [ROWS-1:0] rowEn;
  logic [COLS-1:0] colEn;
  logic [STEP_W-1:0] stepSize;
  logic [ITER_W-1:0] iterCount;

  int checks = 0;
  int failures = 0;
  int mSet [ROWS][COLS];
  int mRst [ROWS][COLS];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pulse_sched dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadMap(loadMap),
    .loadRow(loadRow), .loadCol(loadCol), .loadVal(loadVal),
    .start(start), .fineMode(fineMode), .pulseValid(pulseValid),
    .pulseReady(pulseReady), .rowEn(rowEn), .colEn(colEn),
    .pulseReset(pulseReset), .stepSize(stepSize), .iterCount(iterCount),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic clearModel();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        mSet[r][c] = 0;
        mRst[r][c] = 0;
      end
  endtask

  // Write the whole model into the design while idle (R9)
  task automatic loadAll();
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          loadEn  = 1'b1;
          loadMap = s[0];
          loadRow = 3'(r);
          loadCol = 3'(c);
          loadVal = CNT_W'(s == 0 ? mSet[r][c] : mRst[r][c]);
          @(negedge clk);
        end
    loadEn = 1'b0;
  endtask

  // Expected group from the requirements R2, R3, R5
  task automatic calcExp(output logic [ROWS-1:0] rExp, output logic [COLS-1:0] cExp,
                         output bit rsExp, output bit anyLeft);
    int m [ROWS][COLS];
    int sum, best, piv;
    bit setLeft = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (mSet[r][c] != 0) setLeft = 1;
    rsExp = !setLeft;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        m[r][c] = setLeft ? mSet[r][c] : mRst[r][c];
    best = 0;
    piv = 0;
    for (int c = 0; c < COLS; c++) begin
      sum = 0;
      for (int r = 0; r < ROWS; r++) sum += m[r][c];
      if (sum > best) begin
        best = sum;
        piv = c;
      end
    end
    anyLeft = (best != 0);
    for (int r = 0; r < ROWS; r++) rExp[r] = (m[r][piv] != 0);
    for (int c = 0; c < COLS; c++) begin
      cExp[c] = anyLeft;
      for (int r = 0; r < ROWS; r++)
        if (rExp[r] && m[r][c] == 0) cExp[c] = 1'b0;
    end
  endtask

  task automatic applyModel(input logic [ROWS-1:0] rm, input logic [COLS-1:0] cm, input bit rs);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (rm[r] && cm[c]) begin
          if (rs) begin
            if (mRst[r][c] > 0) mRst[r][c]--;
          end else begin
            if (mSet[r][c] > 0) mSet[r][c]--;
          end
        end
  endtask

  task automatic runCase(input string name, input bit fine, input bit disturb);
    int iters = 0;
    int guard = 0;
    logic [ROWS-1:0] rE;
    logic [COLS-1:0] cE;
    bit rsE, anyE;
    fineMode = fine;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fineMode = 1'b0;
    while (!done && guard < 20000) begin
      loadEn = 1'b0;
      pulseReady = 1'b0;
      start = 1'b0;
      if (pulseValid) begin
        calcExp(rE, cE, rsE, anyE);
        check(anyE, "R6", {name, " pulse offered on empty maps"}, 1, 0);
        check(rowEn === rE, "R2", {name, " rowEn"}, int'(rowEn), int'(rE));
        check(colEn === cE, "R3", {name, " colEn"}, int'(colEn), int'(cE));
        check(pulseReset === rsE, "R5", {name, " pulseReset"}, int'(pulseReset), int'(rsE));
        check(stepSize === STEP_W'(fine ? FINE : COARSE), "R7", {name, " stepSize"},
              int'(stepSize), fine ? FINE : COARSE);
        stepLfsr();
        if (lfsr[0] || lfsr[3]) begin
          pulseReady = 1'b1;
          applyModel(rE, cE, rsE);  // R4: model decrement on acceptance
          iters++;
        end
      end
      if (disturb) begin
        stepLfsr();
        if (lfsr[5:4] == 2'b00) begin  // R9: stray load while busy
          loadEn  = 1'b1;
          loadMap = lfsr[6];
          loadRow = lfsr[9:7];
          loadCol = lfsr[12:10];
          loadVal = 4'hF;
        end
        if (guard == 7) begin  // R9: stray start with the other run type
          start = 1'b1;
          fineMode = ~fine;
        end
      end
      guard++;
      @(negedge clk);
    end
    loadEn = 1'b0;
    pulseReady = 1'b0;
    start = 1'b0;
    fineMode = 1'b0;
    check(done === 1'b1, "R6", {name, " done after run"}, int'(done), 1);
    check(pulseValid === 1'b0, "R6", {name, " no pulse when done"}, int'(pulseValid), 0);
    check(iterCount === ITER_W'(iters), "R8", {name, " iterCount"}, int'(iterCount), iters);
    @(negedge clk);
    check(done === 1'b1, "R6", {name, " done held"}, int'(done), 1);
  endtask

  // Maps should now be empty: a fresh run must finish with no pulses
  task automatic emptyRun(input string name);
    int seen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20 && !done; k++) begin
      if (pulseValid) seen++;
      @(negedge clk);
    end
    check(done === 1'b1, "R6", {name, " empty run done"}, int'(done), 1);
    check(seen == 0, "R9", {name, " pulses after run with stray loads"}, seen, 0);
    check(iterCount === '0, "R8", {name, " empty run iterCount"}, int'(iterCount), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);
    check(pulseValid === 1'b0, "R1", "pulseValid after reset", int'(pulseValid), 0);
    check(iterCount === '0, "R1", "iterCount after reset", int'(iterCount), 0);

    // R1 R6: maps are empty out of reset
    emptyRun("reset");

    // Single cell: one row, one column, three pulses
    clearModel();
    mSet[2][5] = 3;
    loadAll();
    runCase("single", 1'b0, 1'b0);

    // R2 tie: columns 1 and 3 have equal totals, column 1 must lead
    clearModel();
    mSet[0][1] = 2;
    mSet[1][3] = 2;
    mRst[4][6] = 1;
    mRst[4][2] = 1;
    loadAll();
    runCase("tie", 1'b0, 1'b0);

    // Uniform maps in fine mode: whole block per pulse
    clearModel();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        mSet[r][c] = 1;
        mRst[r][c] = 2;
      end
    loadAll();
    runCase("uniform", 1'b1, 1'b0);

    // Reset map only: set phase must be skipped straight to reset (R5)
    clearModel();
    mRst[7][0] = 5;
    mRst[3][0] = 2;
    mRst[3][7] = 4;
    loadAll();
    runCase("resetonly", 1'b0, 1'b0);

    // Pseudo-random maps, both run types, with stray loads and start
    for (int t = 0; t < 4; t++) begin
      clearModel();
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          stepLfsr();
          mSet[r][c] = (lfsr[2:0] < 3'd5) ? int'(lfsr[4:3]) : 0;
          stepLfsr();
          mRst[r][c] = (lfsr[2:0] < 3'd3) ? int'(lfsr[5:3]) : 0;
        end
      loadAll();
      runCase($sformatf("random%0d", t), t[0], 1'b1);
      emptyRun($sformatf("random%0d", t));
    end

    // Full-scale counts on one column
    clearModel();
    for (int r = 0; r < ROWS; r++) mSet[r][4] = 15;
    mSet[0][0] = 15;
    loadAll();
    runCase("fullscale", 1'b1, 1'b0);
    emptyRun("fullscale");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule